// File: doc/BRIEF.md
# Minimised Six-State Moore Sequencer

This block is a Moore finite-state machine. It reads a 2-bit symbol on every rising clock edge and drives a 1-bit output that depends only on the state it holds. Its behaviour is set by a fixed table of six states, numbered 0 to 5. The table has been reduced to four equivalence classes. Original states 1 and 4 act identically, so they share one class. Original states 3 and 5 share another. States 0 and 2 each keep a class of their own.

Seen from its ports, the block cannot be told apart from the full six-state table machine. It is used wherever that table's output sequence is needed, and it costs two state flip-flops instead of three. The current class code is brought out so that the block can be checked against a reference model.

Reset is asserted asynchronously and active-low. Its release is synchronised internally through a short chain of flip-flops.

Top module: `seqtab_fsm`

## Requirements
- R1: `state_cls` carries a class code: 00 for class A (original state 0), 01 for class B (original states 1 and 4), 10 for class C (original state 2) and 11 for class D (original states 3 and 5). `out_bit` is 1 exactly in classes B and C.
- R2: While `rst_n` is low, `state_cls` is 00 and `out_bit` is 0, without waiting for a clock edge.
- R3: After `rst_n` rises, the state holds at class A through the next two rising edges. The first transition takes place on the third rising edge.
- R4: For symbol 00, the next class is B from A, A from B, D from C, and D from D.
- R5: For symbol 01, the next class is C from A, C from B, C from C, and B from D.
- R6: For symbol 10, the next class is A from A, D from B, B from C, and A from D.
- R7: For symbol 11, the next class is D from A, B from B, D from C, and C from D.
- R8: A change on `sym_in` between clock edges has no effect on `out_bit`.
- R9: For any symbol sequence applied after reset, `out_bit` equals the output of the unminimised six-state machine every cycle. In that machine, states 1, 2 and 4 output 1 and states 0, 3 and 5 output 0. `state_cls` always names the class of that machine's state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchroniser |
| sym_in | input | 2 | Input symbol, sampled on each rising edge |
| out_bit | output | 1 | Moore output, decoded from the state alone |
| state_cls | output | 2 | Current equivalence-class code |

## Verification
The hardest situation to reach from the ports is a merged class entered from each of its two original members. For example, class D must be reached both from the path that lands in original state 3 and from the path that lands in original state 5, and every later symbol must then still agree. A directed walk cannot cover every such history. The stimulus therefore drives long random symbol streams into the block and into a six-state reference model held alongside it. It compares the output and the class every cycle, so both members of each merged pair are visited many times with varied continuations. Directed tasks cover each table row from each class, the exact edge of reset release, and input changes in the middle of a cycle.

// File: rtl/seqtab_pkg.sv
`timescale 1ns/1ps
package seqtab_pkg;
  localparam int SYM_W = 2;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_A = 2'b00,
    CLS_B = 2'b01,
    CLS_C = 2'b10,
    CLS_D = 2'b11
  } cls_e;
endpackage

// File: rtl/seqtab_rst_sync.sv
`timescale 1ns/1ps
module seqtab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_core_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], 1'b1};
      end
      assign rst_core_n = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/seqtab_next.sv
`timescale 1ns/1ps
module seqtab_next
  import seqtab_pkg::*;
(
  input  cls_e             cur,
  input  logic [SYM_W-1:0] sym,
  output cls_e             nxt
);
  always_comb begin
    nxt = CLS_A;
    unique case (cur)
      CLS_A: begin
        case (sym)
          2'b00:   nxt = CLS_B;
          2'b01:   nxt = CLS_C;
          2'b10:   nxt = CLS_A;
          default: nxt = CLS_D;
        endcase
      end
      CLS_B: begin
        case (sym)
          2'b00:   nxt = CLS_A;
          2'b01:   nxt = CLS_C;
          2'b10:   nxt = CLS_D;
          default: nxt = CLS_B;
        endcase
      end
      CLS_C: begin
        case (sym)
          2'b00:   nxt = CLS_D;
          2'b01:   nxt = CLS_C;
          2'b10:   nxt = CLS_B;
          default: nxt = CLS_D;
        endcase
      end
      default: begin
        case (sym)
          2'b00:   nxt = CLS_D;
          2'b01:   nxt = CLS_B;
          2'b10:   nxt = CLS_A;
          default: nxt = CLS_C;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/seqtab_out.sv
`timescale 1ns/1ps
module seqtab_out
  import seqtab_pkg::*;
(
  input  cls_e cur,
  output logic mo
);
  always_comb begin
    unique case (cur)
      CLS_B, CLS_C: mo = 1'b1;
      default:      mo = 1'b0;
    endcase
  end
endmodule

// File: rtl/seqtab_fsm.sv
`timescale 1ns/1ps
module seqtab_fsm
  import seqtab_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_in,
  output logic             out_bit,
  output logic [CLS_W-1:0] state_cls
);
  logic rst_core_n;
  cls_e cls_q;
  cls_e cls_d;

  seqtab_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  seqtab_next i_next (
    .cur (cls_q),
    .sym (sym_in),
    .nxt (cls_d)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cls_q <= CLS_A;
    else             cls_q <= cls_d;
  end

  seqtab_out i_out (
    .cur (cls_q),
    .mo  (out_bit)
  );

  assign state_cls = cls_q;
endmodule

// File: rtl/seqtab_fsm_chk.sv
`timescale 1ns/1ps
module seqtab_fsm_chk (
  input logic       clk,
  input logic       rst_core_n,
  input logic [1:0] sym_in,
  input logic       out_bit,
  input logic [1:0] state_cls
);
  assert_reset_class_R2: assert property (@(posedge clk)
    !rst_core_n |-> (state_cls == 2'b00 && out_bit == 1'b0));

  assert_out_code_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_bit == (state_cls[1] ^ state_cls[0]));

  assert_row00_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sym_in == 2'b00 && state_cls[1]) |=> state_cls == 2'b11);

  assert_row01_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sym_in == 2'b01 && state_cls != 2'b11) |=> state_cls == 2'b10);

  assert_row10_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sym_in == 2'b10 && (state_cls == 2'b00 || state_cls == 2'b11)) |=> state_cls == 2'b00);

  assert_row11_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sym_in == 2'b11 && state_cls == 2'b01) |=> state_cls == 2'b01);

  assert_release_R3: assert property (@(posedge clk)
    $rose(rst_core_n) |-> state_cls == 2'b00);
endmodule

bind seqtab_fsm seqtab_fsm_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .sym_in     (sym_in),
  .out_bit    (out_bit),
  .state_cls  (state_cls)
);

// File: tb/test_seqtab_fsm.sv
`timescale 1ns/1ps
module test_seqtab_fsm;
  logic       clk;
  logic       rst_n;
  logic [1:0] sym_in;
  logic       out_bit;
  logic [1:0] state_cls;

  int n_chk;
  int n_err;
  bit done;

  seqtab_fsm i_seqtab_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_in    (sym_in),
    .out_bit   (out_bit),
    .state_cls (state_cls)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // six-state reference table
  function automatic int ref_next(int s, logic [1:0] x);
    case (s)
      0: case (x) 2'b00: return 1; 2'b01: return 2; 2'b10: return 0; default: return 5; endcase
      1: case (x) 2'b00: return 0; 2'b01: return 2; 2'b10: return 3; default: return 1; endcase
      2: case (x) 2'b00: return 5; 2'b01: return 2; 2'b10: return 4; default: return 3; endcase
      3: case (x) 2'b00: return 5; 2'b01: return 1; 2'b10: return 0; default: return 2; endcase
      4: case (x) 2'b00: return 0; 2'b01: return 2; 2'b10: return 5; default: return 1; endcase
      default: case (x) 2'b00: return 5; 2'b01: return 4; 2'b10: return 0; default: return 2; endcase
    endcase
  endfunction

  function automatic logic ref_out(int s);
    return (s == 1 || s == 2 || s == 4);
  endfunction

  function automatic logic [1:0] cls_of(int s);
    case (s)
      0: return 2'b00;
      1, 4: return 2'b01;
      2: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic int rep_of(logic [1:0] c);
    case (c)
      2'b00: return 0;
      2'b01: return 1;
      2'b10: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // full reset with release done at a falling edge, then wait out the synchroniser
  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    sym_in = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic step(logic [1:0] x);
    sym_in = x;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_R2();
    @(negedge clk);
    sym_in = 2'b01;
    #1 rst_n = 1'b0;
    #0.5;
    check("R2", "class in reset (async)", state_cls, 0);
    check("R2", "out in reset", out_bit, 0);
    repeat (3) @(negedge clk);
    check("R2", "class held in reset", state_cls, 0);
  endtask

  task automatic t_release_R3();
    @(negedge clk);
    rst_n  = 1'b0;
    sym_in = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3", "class after edge 1", state_cls, 0);
    @(posedge clk); @(negedge clk);
    check("R3", "class after edge 2", state_cls, 0);
    @(posedge clk); @(negedge clk);
    check("R3", "class after edge 3", state_cls, 1);
  endtask

  task automatic t_rows();
    logic [1:0] path [4];
    path[0] = 2'b10; path[1] = 2'b00; path[2] = 2'b01; path[3] = 2'b11;
    for (int c = 0; c < 4; c++) begin
      for (int x = 0; x < 4; x++) begin
        do_reset();
        step(path[c]);
        check("R1", "class reached", state_cls, c);
        check("R1", "out of class", out_bit, ref_out(rep_of(c[1:0])));
        step(x[1:0]);
        case (x)
          0: check("R4", $sformatf("class %0d sym 00", c), state_cls, cls_of(ref_next(rep_of(c[1:0]), 2'b00)));
          1: check("R5", $sformatf("class %0d sym 01", c), state_cls, cls_of(ref_next(rep_of(c[1:0]), 2'b01)));
          2: check("R6", $sformatf("class %0d sym 10", c), state_cls, cls_of(ref_next(rep_of(c[1:0]), 2'b10)));
          default: check("R7", $sformatf("class %0d sym 11", c), state_cls, cls_of(ref_next(rep_of(c[1:0]), 2'b11)));
        endcase
      end
    end
  endtask

  task automatic t_moore_R8();
    logic [1:0] path [4];
    logic       o0;
    path[0] = 2'b10; path[1] = 2'b00; path[2] = 2'b01; path[3] = 2'b11;
    for (int c = 0; c < 4; c++) begin
      do_reset();
      step(path[c]);
      o0 = out_bit;
      for (int x = 0; x < 4; x++) begin
        sym_in = x[1:0];
        #0.3;
        check("R8", $sformatf("out stable class %0d sym %0d", c, x), out_bit, o0);
      end
    end
  endtask

  task automatic t_lockstep_R9();
    int s;
    logic [1:0] x;
    do_reset();
    s = 0;
    for (int k = 0; k < 4000; k++) begin
      x = 2'($urandom_range(3, 0));
      step(x);
      s = ref_next(s, x);
      n_chk++;
      if (out_bit != ref_out(s) || state_cls != cls_of(s)) begin
        n_err++;
        $display("FAIL R9 cycle %0d: actual out %0d cls %0d expected out %0d cls %0d",
                 k, out_bit, state_cls, ref_out(s), cls_of(s));
      end
    end
  endtask

  initial begin
    n_chk  = 0;
    n_err  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    sym_in = 2'b00;
    do_reset();
    t_reset_R2();
    t_release_R3();
    t_rows();
    t_moore_R8();
    t_lockstep_R9();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule